// File: doc/BRIEF.md
# Four-Segment Piecewise-Linear Pixel Compander

This block reshapes a 13-bit linear pixel code into a narrower code. Its main use is to squeeze an extended dynamic range into a 10-bit word. The transfer curve has four straight segments. Three knee positions divide the input range into the four segments. Each segment has its own slope, held in steps of 1/256, and its own signed intercept. The output is the intercept plus the slope times the input, rounded to the nearest code and then saturated into 0 to 1023. The block has two other output modes. One clips the input at 4095 to give a 12-bit code. The other passes the 13-bit input through unchanged.

Software programs the curve and the mode through a write-only register port. After reset the block is in pass-through mode and the curve is linear. The datapath has two pipeline stages. The first stage compares the input against the knees, multiplies and rounds. The second stage adds the intercept and saturates. A valid flag travels with the data through both stages.

Top module: `pwl_compander`

## Requirements
- R1: After reset, out_valid is 0, out_code is 0 and the mode is pass-through. The curve registers hold a linear curve: the knees are at 2048, 4096 and 6144, every slope is 32 and every intercept is 8. Input 4096 in companded mode therefore gives 520.
- R2: A write with cfg_we high lands at the next clock edge. cfg_addr selects the target: 0 is the mode (bits 1:0); 1, 2 and 3 are knees 1 to 3 (13 bits); 4 to 7 are slopes 1 to 4 (bits 8:0, unsigned, units of 1/256); 8 to 11 are intercepts 1 to 4 (bits 10:0, two's complement). A sample that enters on the same edge as a write uses the old values.
- R3: In companded mode, segment 1 is chosen when the input is below knee 1, segment 2 when it is below knee 2, and segment 3 when it is below knee 3. Otherwise segment 4 is chosen. An input equal to a knee therefore belongs to the higher segment.
- R4: Mode 1 is the companded mode. Its output is intercept + floor((slope*input + 128)/256), clamped to at most 1023.
- R5: Mode 2 is the clip mode. Its output is the input if the input is at most 4095; otherwise it is 4095.
- R6: Mode 0 and mode 3 pass the 13-bit input through unchanged.
- R7: out_valid is in_valid delayed by exactly two clock cycles. The output code belongs to the input sampled two edges earlier.
- R8: out_code keeps its value in any cycle where out_valid is 0.
- R9: In companded mode, a negative result of the sum gives output 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register select |
| cfg_wdata | input | 13 | Register write data |
| in_valid | input | 1 | Input sample valid |
| in_code | input | 13 | Linear input pixel code |
| out_valid | output | 1 | Output sample valid |
| out_code | output | 13 | Output code (10, 12 or 13 significant bits by mode) |

## Verification
The assertions take for granted that the knees are programmed in strictly increasing order. They also take for granted that in_valid is low while reset is active, so that the two-cycle valid relation holds from the first edge after reset. The stimulus writes only knee sets that are in order. It holds in_valid low during reset. It reprograms the curve only between bursts of samples, except for one write that deliberately overlaps a sample to show the old-value rule. Negative intercepts, slopes at full scale, and inputs placed exactly on each knee and one code below it drive the saturation and segment-boundary cases.

// File: rtl/pwl_compander.sv
module pwl_compander #(
  parameter int IN_W    = 13,
  parameter int OUT_W   = 10,
  parameter int CLIP_W  = 12,
  parameter int SLOPE_W = 9,
  parameter int FRAC_W  = 8,
  parameter int OFS_W   = 11,
  parameter int ADDR_W  = 4,
  parameter int DEF_OFS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [IN_W-1:0]   cfg_wdata,
  input  logic              in_valid,
  input  logic [IN_W-1:0]   in_code,
  output logic              out_valid,
  output logic [IN_W-1:0]   out_code
);
  localparam int PROD_W   = IN_W + SLOPE_W;
  localparam int SHR_W    = PROD_W + 1 - FRAC_W;
  localparam int SUM_W    = SHR_W + 2;
  localparam int OUT_MAX  = (1 << OUT_W) - 1;
  localparam int CLIP_MAX = (1 << CLIP_W) - 1;
  localparam int DEF_SLP  = 1 << (FRAC_W - (IN_W - OUT_W));
  localparam logic [1:0] MODE_COMP = 2'd1;
  localparam logic [1:0] MODE_CLIP = 2'd2;

  logic [1:0]             mode_q;
  logic [IN_W-1:0]        knee_q  [3];
  logic [SLOPE_W-1:0]     slope_q [4];
  logic [OFS_W-1:0]       ofs_q   [4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 2'd0;
      for (int k = 0; k < 3; k++) knee_q[k] <= IN_W'((k + 1) << (IN_W - 2));
      for (int k = 0; k < 4; k++) begin
        slope_q[k] <= SLOPE_W'(DEF_SLP);
        ofs_q[k]   <= OFS_W'(DEF_OFS);
      end
    end else if (cfg_we) begin
      if (cfg_addr == '0) mode_q <= cfg_wdata[1:0];
      for (int k = 0; k < 3; k++)
        if (cfg_addr == ADDR_W'(1 + k)) knee_q[k] <= cfg_wdata;
      for (int k = 0; k < 4; k++) begin
        if (cfg_addr == ADDR_W'(4 + k)) slope_q[k] <= cfg_wdata[SLOPE_W-1:0];
        if (cfg_addr == ADDR_W'(8 + k)) ofs_q[k]   <= cfg_wdata[OFS_W-1:0];
      end
    end
  end

  logic [1:0]        seg;
  logic [PROD_W-1:0] prod;
  logic [PROD_W:0]   prod_rnd;

  assign seg = (in_code < knee_q[0]) ? 2'd0 :
               (in_code < knee_q[1]) ? 2'd1 :
               (in_code < knee_q[2]) ? 2'd2 : 2'd3;
  assign prod     = PROD_W'(slope_q[seg]) * PROD_W'(in_code);
  assign prod_rnd = {1'b0, prod} + (PROD_W+1)'(1 << (FRAC_W - 1));

  logic              s1_valid;
  logic [1:0]        s1_mode;
  logic [IN_W-1:0]   s1_code;
  logic [SHR_W-1:0]  s1_shr;
  logic [OFS_W-1:0]  s1_ofs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_mode  <= 2'd0;
      s1_code  <= '0;
      s1_shr   <= '0;
      s1_ofs   <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_mode <= mode_q;
        s1_code <= in_code;
        s1_shr  <= prod_rnd[PROD_W:FRAC_W];
        s1_ofs  <= ofs_q[seg];
      end
    end
  end

  logic signed [SUM_W-1:0] sum;
  logic [OUT_W-1:0]        comp;
  logic [IN_W-1:0]         clip;
  logic [IN_W-1:0]         result;

  assign sum  = $signed({2'b00, s1_shr}) +
                $signed({{(SUM_W-OFS_W){s1_ofs[OFS_W-1]}}, s1_ofs});
  assign comp = sum[SUM_W-1]                              ? '0 :
                (sum[SUM_W-2:0] > (SUM_W-1)'(OUT_MAX))    ? OUT_W'(OUT_MAX) :
                                                            sum[OUT_W-1:0];
  assign clip = (s1_code > IN_W'(CLIP_MAX)) ? IN_W'(CLIP_MAX) : s1_code;

  always_comb begin
    case (s1_mode)
      MODE_COMP: result = {{(IN_W-OUT_W){1'b0}}, comp};
      MODE_CLIP: result = clip;
      default:   result = s1_code;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_code  <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_code <= result;
    end
  end
endmodule

module pwl_compander_chk #(
  parameter int IN_W = 13
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [IN_W-1:0] in_code,
  input logic            out_valid,
  input logic [IN_W-1:0] out_code,
  input logic [1:0]      mode_q
);
  logic [1:0] cyc;
  always_ff @(posedge clk) begin
    if (!rst_n) cyc <= 2'd0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  p_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && out_valid && ($past(mode_q, 2) == 2'd0 || $past(mode_q, 2) == 2'd3))
    |-> (out_code == $past(in_code, 2)));

  p_comp_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && out_valid && $past(mode_q, 2) == 2'd1)
    |-> (out_code <= IN_W'(1023)));

  p_clip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && out_valid && $past(mode_q, 2) == 2'd2)
    |-> (out_code == (($past(in_code, 2) > IN_W'(4095)) ? IN_W'(4095) : $past(in_code, 2))));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd1 && !out_valid) |-> $stable(out_code));
endmodule

bind pwl_compander pwl_compander_chk #(.IN_W(IN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
  .out_valid(out_valid), .out_code(out_code), .mode_q(mode_q)
);

// File: tb/pwl_compander_tb.sv
module pwl_compander_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [12:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic [12:0] in_code = '0;
  logic        out_valid;
  logic [12:0] out_code;

  always #5 clk = ~clk;

  pwl_compander dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_code(in_code),
    .out_valid(out_valid), .out_code(out_code)
  );

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";
  bit run_chk = 1'b0;

  int m_mode;
  int m_knee [3];
  int m_slope [4];
  int m_ofs [4];
  bit m_v1, m_ov;
  int m_r1, m_oc;

  function automatic int ref_calc(int c);
    int s, v;
    if (m_mode == 1) begin
      if (c < m_knee[0]) s = 0;
      else if (c < m_knee[1]) s = 1;
      else if (c < m_knee[2]) s = 2;
      else s = 3;
      v = m_ofs[s] + (m_slope[s] * c + 128) / 256;
      if (v < 0) v = 0;
      if (v > 1023) v = 1023;
      return v;
    end else if (m_mode == 2) begin
      return (c > 4095) ? 4095 : c;
    end
    return c;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0;
      for (int k = 0; k < 3; k++) m_knee[k] = 2048 * (k + 1);
      for (int k = 0; k < 4; k++) begin m_slope[k] = 32; m_ofs[k] = 8; end
      m_v1 = 0; m_ov = 0; m_r1 = 0; m_oc = 0;
    end else begin
      m_ov = m_v1;
      if (m_v1) m_oc = m_r1;
      m_v1 = in_valid;
      if (in_valid) m_r1 = ref_calc(int'(in_code));
      if (cfg_we) begin
        case (cfg_addr)
          4'd0: m_mode = int'(cfg_wdata[1:0]);
          4'd1, 4'd2, 4'd3: m_knee[cfg_addr - 1] = int'(cfg_wdata);
          4'd4, 4'd5, 4'd6, 4'd7: m_slope[cfg_addr - 4] = int'(cfg_wdata[8:0]);
          4'd8, 4'd9, 4'd10, 4'd11: begin
            m_ofs[cfg_addr - 8] = int'(cfg_wdata[10:0]);
            if (m_ofs[cfg_addr - 8] >= 1024) m_ofs[cfg_addr - 8] -= 2048;
          end
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && run_chk) begin
      n_cmp++;
      if (out_valid !== m_ov || out_code !== 13'(m_oc)) begin
        n_bad++;
        $display("FAIL %s model: valid=%0b code=%0d expected valid=%0b code=%0d",
                 cur_req, out_valid, out_code, m_ov, m_oc);
      end
    end
  end

  task automatic wr(input int a, input int d);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 13'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send_chk(input int c, input int exp, input string req);
    cur_req = req;
    in_valid = 1'b1; in_code = 13'(c);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    n_cmp++;
    if (out_valid !== 1'b1 || out_code !== 13'(exp)) begin
      n_bad++;
      $display("FAIL %s in=%0d: valid=%0b code=%0d expected valid=1 code=%0d",
               req, c, out_valid, out_code, exp);
    end
  endtask

  task automatic burst(input int n, input string req);
    cur_req = req;
    for (int i = 0; i < n; i++) begin
      in_valid = ($urandom_range(0, 3) != 0);
      in_code = 13'($urandom_range(0, 8191));
      @(negedge clk);
    end
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: cycles=%0d expected below 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    n_cmp++;
    if (out_valid !== 1'b0 || out_code !== 13'd0) begin
      n_bad++;
      $display("FAIL R1 reset: valid=%0b code=%0d expected valid=0 code=0", out_valid, out_code);
    end
    run_chk = 1'b1;

    send_chk(8191, 8191, "R1");
    send_chk(1234, 1234, "R6");
    burst(40, "R6");

    wr(0, 1);
    send_chk(4096, 520, "R1");
    send_chk(8191, 1023, "R4");
    send_chk(0, 8, "R4");
    burst(60, "R1");

    wr(1, 512); wr(2, 2048); wr(3, 5000);
    wr(4, 110); wr(5, 52); wr(6, 22); wr(7, 20);
    wr(8, 8); wr(9, 96); wr(10, 334); wr(11, 368);
    send_chk(511, 228, "R3");
    send_chk(512, 200, "R3");
    send_chk(2047, 512, "R3");
    send_chk(2048, 510, "R3");
    send_chk(4999, 764, "R3");
    send_chk(5000, 759, "R2");
    burst(200, "R4");

    cur_req = "R7";
    for (int i = 0; i < 30; i++) begin
      in_valid = 1'b1; in_code = 13'($urandom_range(0, 8191));
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (3) @(negedge clk);

    cur_req = "R2";
    in_valid = 1'b1; in_code = 13'd4999;
    cfg_we = 1'b1; cfg_addr = 4'd6; cfg_wdata = 13'd0;
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    n_cmp++;
    if (out_code !== 13'd764) begin
      n_bad++;
      $display("FAIL R2 old-value: code=%0d expected 764", out_code);
    end
    send_chk(4999, 334, "R2");

    wr(8, 2048 - 600);
    send_chk(0, 0, "R9");
    send_chk(100, 0, "R9");
    wr(7, 511); wr(11, 1023);
    send_chk(8191, 1023, "R4");
    burst(200, "R9");

    wr(0, 2);
    send_chk(4095, 4095, "R5");
    send_chk(4096, 4095, "R5");
    send_chk(100, 100, "R5");
    burst(100, "R5");

    wr(0, 3);
    send_chk(6000, 6000, "R6");
    burst(100, "R6");

    cur_req = "R8";
    in_valid = 1'b1; in_code = 13'd777;
    @(negedge clk);
    in_valid = 1'b0; in_code = 13'd1;
    repeat (6) @(negedge clk);
    n_cmp++;
    if (out_valid !== 1'b0 || out_code !== 13'd777) begin
      n_bad++;
      $display("FAIL R8 hold: valid=%0b code=%0d expected valid=0 code=777", out_valid, out_code);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule